// File: doc/BRIEF.md
# XNOR-Feedback Pseudo-Random Sequence Source

This block produces a stream of pseudo-random words from a linear feedback shift register that uses XNOR feedback. The register state is the output, driven continuously. A synchronous reset loads a fixed seed. After that, the register moves forward by one step only when the consumer pulses an acknowledge input to say it has taken the current word. When the acknowledge is low, the word is held.

With XNOR feedback the all-zero word is an ordinary member of the cycle. The all-ones word is the one state the register can never leave. The width and the seed are parameters, and the width can be any value from 3 to 16. At the default 8-bit width, a sequence started from any legal seed repeats every 255 steps and never shows 0xFF.

Top module: `prng_xnor`

## Requirements
- R1: The default parameters give an 8-bit output and a seed of 0x12.
- R2: When `rst` is high at a rising clock edge, the register loads the seed, and `val` shows the seed straight after that edge. This holds whatever the level of `got`, because reset takes priority.
- R3: When `rst` and `got` are both low at an edge, `val` keeps its value.
- R4: When `got` is high and `rst` is low at an edge, the register moves exactly one step. The step shifts the word left by one bit and puts a new bit into bit 0. For 8 bits, that new bit is the inverted XOR of the old bits 7, 5, 4 and 3.
- R5: Starting from the seed 0x12, the words produced in order are 0x12, 0x24, 0x48, 0x90, 0x21, 0x42, 0x85, 0x0A, 0x14, 0x28, 0x51, 0xA2.
- R6: The all-zero word is part of the cycle: 0x80 steps to 0x00, 0x00 steps to 0x01, and 0x01 steps to 0x03.
- R7: After 255 steps from the seed, `val` is 0x12 again, and 0x12 does not appear at any earlier step.
- R8: The word 0xFF never appears in the sequence, and 0xFE steps to 0xFD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset; loads the seed |
| got | input | 1 | Consumer acknowledge; a high level advances the register by one step |
| val | output | WIDTH | Current pseudo-random word |

## Verification
The hardest states to reach are the far side of the cycle: the pass through zero, the step out of 0xFE, and the return to the seed. These can only be reached by stepping through up to 255 states from the seed. The stimulus holds `got` high across one whole period and compares every word with an independent step model. At the transitions named in R6, R7 and R8 it adds checks of its own. Before and after that run, short stretches with `got` low confirm that the register holds, and reset is applied with `got` high to show that reset wins.

// File: rtl/prng_xnor.sv
module prng_xnor #(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] SEED = 8'h12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             got,
  output logic [WIDTH-1:0] val
);

  function automatic logic [31:0] tap_mask(int unsigned w);
    case (w)
      3:       return 32'h0006;
      4:       return 32'h000C;
      5:       return 32'h0014;
      6:       return 32'h0030;
      7:       return 32'h0060;
      8:       return 32'h00B8;
      9:       return 32'h0110;
      10:      return 32'h0240;
      11:      return 32'h0500;
      12:      return 32'h0829;
      13:      return 32'h100D;
      14:      return 32'h2015;
      15:      return 32'h6000;
      16:      return 32'hD008;
      default: return 32'h0000;
    endcase
  endfunction

  localparam logic [31:0]      MASK_FULL = tap_mask(WIDTH);
  localparam logic [WIDTH-1:0] TAPS      = MASK_FULL[WIDTH-1:0];

  logic [WIDTH-1:0] state;
  logic             fb;

  assign fb  = ~^(state & TAPS);
  assign val = state;

  always_ff @(posedge clk) begin
    if (rst)
      state <= SEED;
    else if (got)
      state <= {state[WIDTH-2:0], fb};
  end

endmodule

// File: rtl/prng_xnor_chk.sv
module prng_xnor_chk #(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] SEED = 8'h12
) (
  input logic             clk,
  input logic             rst,
  input logic             got,
  input logic [WIDTH-1:0] val
);

  logic armed = 1'b0;
  always_ff @(posedge clk)
    if (rst) armed <= 1'b1;

  p_seed_load_r2: assert property (@(posedge clk)
    rst |=> val == SEED);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    !got |=> $stable(val));

  p_shift_step_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    got |=> val[WIDTH-1:1] == $past(val[WIDTH-2:0]));

  p_zero_exit_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    (got && val == '0) |=> val == WIDTH'(1));

  p_no_lockup_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    val != {WIDTH{1'b1}});

endmodule

bind prng_xnor prng_xnor_chk #(.WIDTH(WIDTH), .SEED(SEED)) u_chk (
  .clk(clk), .rst(rst), .got(got), .val(val)
);

// File: tb/prng_xnor_tb.sv
`timescale 1ns/1ps
module prng_xnor_tb;

  localparam int NV = 12;
  localparam logic [7:0] SEQ [NV] = '{8'h12, 8'h24, 8'h48, 8'h90, 8'h21, 8'h42,
                                      8'h85, 8'h0A, 8'h14, 8'h28, 8'h51, 8'hA2};

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       got = 1'b0;
  logic [7:0] val;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prng_xnor u_dut (.clk(clk), .rst(rst), .got(got), .val(val));

  function automatic logic [7:0] nxt(logic [7:0] s);
    return {s[6:0], ~(s[7] ^ s[5] ^ s[4] ^ s[3])};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: val=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(logic r, logic g);
    rst = r;
    got = g;
    @(negedge clk);
    rst = 1'b0;
    got = 1'b0;
  endtask

  initial begin
    logic [7:0] m;
    logic [7:0] prev;
    @(negedge clk);
    // R1, R2: default seed visible right after reset
    cyc(1'b1, 1'b0);
    check("R1/R2 reset", val, 8'h12);

    // R5: vector table walk
    for (int i = 1; i < NV; i++) begin
      cyc(1'b0, 1'b1);
      check("R5 sequence", val, SEQ[i]);
    end

    // R3: hold while got low
    prev = val;
    for (int i = 0; i < 5; i++) begin
      cyc(1'b0, 1'b0);
      check("R3 hold", val, prev);
    end
    cyc(1'b0, 1'b1);
    check("R4 step after hold", val, nxt(prev));

    // R2: reset wins over got
    cyc(1'b1, 1'b1);
    check("R2 reset priority", val, 8'h12);

    // R4, R6, R7, R8: full period against the model
    m = 8'h12;
    for (int k = 1; k <= 255; k++) begin
      prev = m;
      m = nxt(m);
      cyc(1'b0, 1'b1);
      check("R4 model", val, m);
      if (val == 8'hFF) check("R8 no all-ones", val, 8'h00);
      if (prev == 8'h80) check("R6 80->00", val, 8'h00);
      if (prev == 8'h00) check("R6 00->01", val, 8'h01);
      if (prev == 8'h01) check("R6 01->03", val, 8'h03);
      if (prev == 8'hFE) check("R8 FE->FD", val, 8'hFD);
      if (k < 255 && val == 8'h12) check("R7 early repeat", val, 8'h00);
      if (k % 64 == 0) begin
        cyc(1'b0, 1'b0);
        check("R3 hold mid-cycle", val, m);
      end
    end
    check("R7 period 255", val, 8'h12);

    // R2: reset mid-sequence after a few steps
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b0);
    check("R2 reset mid-run", val, 8'h12);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog: val=%02h expected=done", val);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule